// File: doc/BRIEF.md
# Calendar Counter with Alarm Match

This block keeps wall-clock time as packed calendar fields. A date word holds the year, the month and the day of the month. A time word holds the week of the month, the day of the week, hours, minutes and seconds. An external one-second tick moves the calendar forward by one second. The carry runs on through minutes, hours, days, months and years, with full Gregorian month lengths. The day of the week and the week of the month follow the day count.

Software loads either calendar word, or either word of an alarm, through a single write port. A select field picks the target. Software normally writes the date word first and the time word second. All four words can be read at any time on output ports. When a tick moves the calendar onto the alarm's year, month, day, hour, minute and second, the block raises a one-clock match pulse. The tick source and any interrupt or status logic sit outside the block.

Top module: `cal_keeper`

## Requirements
- R1: After a synchronous active-low reset the date reads year 2000, month 1, day 1. The time reads week 1, weekday 1 and 00:00:00. Both alarm words read 0 and match_o is low.
- R2: Each accepted tick adds one second. Seconds roll from 59 to 0 and carry into minutes. Minutes roll from 59 to 0 and carry into hours. Hours roll from 23 to 0 and carry into the day. Without a tick the calendar holds.
- R3: On a day carry the day of the month rolls back to 1 after the month's last day and the month advances. April, June, September and November have 30 days. The other months except February have 31.
- R4: February has 29 days when the year is divisible by 4, unless the year is divisible by 100 but not by 400. In all other years it has 28.
- R5: A carry out of month 12 sets the month to 1 and adds one to the year.
- R6: Each day carry moves the weekday on by one, wrapping 7 to 1. Whenever the day of the month changes, through a tick or a date write, the week of the month becomes (day + 6) / 7 using integer division.
- R7: wr_sel_i selects the target of a write: 0 is the calendar date, 1 the calendar time, 2 the alarm date and 3 the alarm time. Date words place the year at [20:9], the month at [8:5] and the day at [4:0]. Time words place the week of the month at [22:20], the weekday at [19:17], hours at [16:12], minutes at [11:6] and seconds at [5:0]. A written value reads back on the matching output in the next cycle.
- R8: A write to either calendar word in the same cycle as a tick takes effect, and that tick is dropped.
- R9: match_o is high for exactly one clock, in the same cycle that a tick's updated calendar first shows on the outputs. It fires only if year, month, day, hour, minute and second all equal the alarm. The alarm's week and weekday fields play no part in the compare.
- R10: A software write that makes the calendar equal the alarm does not raise match_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | One-second advance request, one clock wide |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 calendar date, 1 calendar time, 2 alarm date, 3 alarm time |
| wr_data_i | input | 23 | Write data in the date or time word layout |
| date_o | output | 21 | Running calendar date word |
| time_o | output | 23 | Running calendar time word |
| alarm_date_o | output | 21 | Alarm date word |
| alarm_time_o | output | 23 | Alarm time word |
| match_o | output | 1 | Alarm match pulse |

## Verification
Every result is due one clock after its stimulus. A write or tick sampled on a rising edge shows on date_o, time_o and the alarm outputs right after that edge. The match pulse comes from the same edge and drops on the next one. The bench drives inputs on falling edges for one cycle and reads all outputs on the next falling edge. It checks match_o again one cycle later to confirm it is gone. Calendar cases load a date and time a step before a boundary, issue one tick and compare both words. Those boundaries include month ends, February across leap and century years, and the year end.

// File: rtl/cal_pkg.sv
// Shared field widths, write-target encoding and calendar helper functions.
// Assumes a 12-bit binary year and 1-based month, day and weekday numbering.
package cal_pkg;

    localparam int YEAR_W = 12;
    localparam int MON_W  = 4;
    localparam int DAY_W  = 5;
    localparam int WOM_W  = 3;
    localparam int DOW_W  = 3;
    localparam int HR_W   = 5;
    localparam int MIN_W  = 6;
    localparam int SEC_W  = 6;

    localparam int DATE_W = YEAR_W + MON_W + DAY_W;
    localparam int CLK_W  = HR_W + MIN_W + SEC_W;
    localparam int TIME_W = WOM_W + DOW_W + CLK_W;

    typedef enum logic [1:0] {
        TGT_CAL_DATE = 2'd0,
        TGT_CAL_TIME = 2'd1,
        TGT_ALM_DATE = 2'd2,
        TGT_ALM_TIME = 2'd3
    } wr_target_e;

    // Gregorian leap-year test.
    function automatic logic is_leap(input logic [YEAR_W-1:0] y);
        logic by4, by100, by400;
        by4   = (y % YEAR_W'(4))   == '0;
        by100 = (y % YEAR_W'(100)) == '0;
        by400 = (y % YEAR_W'(400)) == '0;
        return by4 && (!by100 || by400);
    endfunction

    // Last day of a month; out-of-range month codes count as 31 days.
    function automatic logic [DAY_W-1:0] last_day(input logic [YEAR_W-1:0] y,
                                                 input logic [MON_W-1:0]  m);
        case (m)
            MON_W'(2):  return is_leap(y) ? DAY_W'(29) : DAY_W'(28);
            MON_W'(4), MON_W'(6), MON_W'(9), MON_W'(11): return DAY_W'(30);
            default:    return DAY_W'(31);
        endcase
    endfunction

    // Week of the month for a given day: ceiling of day / 7.
    function automatic logic [WOM_W-1:0] week_of(input logic [DAY_W-1:0] d);
        logic [DAY_W:0] s;
        s = {1'b0, d} + (DAY_W+1)'(6);
        return WOM_W'(s / (DAY_W+1)'(7));
    endfunction

endpackage

// File: rtl/cal_tod.sv
// Time-of-day counter: seconds, minutes and hours.
// Assumes tick_i already excludes cycles with a calendar write; load_i wins.
// Exposes the next-state values and the carry into the day.
module cal_tod
    import cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [HR_W-1:0]  ld_hour_i,
    input  logic [MIN_W-1:0] ld_min_i,
    input  logic [SEC_W-1:0] ld_sec_i,
    output logic [HR_W-1:0]  hour_o,
    output logic [MIN_W-1:0] min_o,
    output logic [SEC_W-1:0] sec_o,
    output logic [HR_W-1:0]  nxt_hour_o,
    output logic [MIN_W-1:0] nxt_min_o,
    output logic [SEC_W-1:0] nxt_sec_o,
    output logic             day_carry_o
);
    localparam logic [SEC_W-1:0] SEC_LAST  = SEC_W'(59);
    localparam logic [MIN_W-1:0] MIN_LAST  = MIN_W'(59);
    localparam logic [HR_W-1:0]  HOUR_LAST = HR_W'(23);

    logic [HR_W-1:0]  hour_q;
    logic [MIN_W-1:0] min_q;
    logic [SEC_W-1:0] sec_q;
    logic sec_wrap, min_wrap, hour_wrap;

    // Next-state values for one second of advance, with carries.
    always_comb begin
        sec_wrap   = sec_q  >= SEC_LAST;
        min_wrap   = min_q  >= MIN_LAST;
        hour_wrap  = hour_q >= HOUR_LAST;
        nxt_sec_o  = sec_q;
        nxt_min_o  = min_q;
        nxt_hour_o = hour_q;
        if (tick_i) begin
            nxt_sec_o = sec_wrap ? '0 : sec_q + 1'b1;
            if (sec_wrap) begin
                nxt_min_o = min_wrap ? '0 : min_q + 1'b1;
                if (min_wrap) begin
                    nxt_hour_o = hour_wrap ? '0 : hour_q + 1'b1;
                end
            end
        end
        day_carry_o = tick_i && sec_wrap && min_wrap && hour_wrap;
    end

    // Time-of-day registers: reset, software load, or advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hour_q <= '0;
            min_q  <= '0;
            sec_q  <= '0;
        end else if (load_i) begin
            hour_q <= ld_hour_i;
            min_q  <= ld_min_i;
            sec_q  <= ld_sec_i;
        end else begin
            hour_q <= nxt_hour_o;
            min_q  <= nxt_min_o;
            sec_q  <= nxt_sec_o;
        end
    end

    assign hour_o = hour_q;
    assign min_o  = min_q;
    assign sec_o  = sec_q;

    // R2: seconds roll from 59 to 0 on a tick
    assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && sec_q == SEC_LAST) |=> (sec_q == '0));

    // R2: without tick or load the time of day holds
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !load_i) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q)));

    // R8: a load always lands as written
    assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (sec_q == $past(ld_sec_i) && min_q == $past(ld_min_i)));

endmodule

// File: rtl/cal_date.sv
// Date counter: year, month, day of month, weekday and week of month.
// Assumes adv_i is the day carry from the time-of-day counter, already
// suppressed in cycles that carry a calendar write.
module cal_date
    import cal_pkg::*;
#(
    parameter logic [YEAR_W-1:0] RESET_YEAR = YEAR_W'(2000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic              ld_date_i,
    input  logic              ld_time_i,
    input  logic [YEAR_W-1:0] ld_year_i,
    input  logic [MON_W-1:0]  ld_mon_i,
    input  logic [DAY_W-1:0]  ld_day_i,
    input  logic [WOM_W-1:0]  ld_wom_i,
    input  logic [DOW_W-1:0]  ld_dow_i,
    output logic [YEAR_W-1:0] year_o,
    output logic [MON_W-1:0]  mon_o,
    output logic [DAY_W-1:0]  day_o,
    output logic [WOM_W-1:0]  wom_o,
    output logic [DOW_W-1:0]  dow_o,
    output logic [YEAR_W-1:0] nxt_year_o,
    output logic [MON_W-1:0]  nxt_mon_o,
    output logic [DAY_W-1:0]  nxt_day_o
);
    localparam logic [MON_W-1:0] MON_LAST = MON_W'(12);
    localparam logic [DOW_W-1:0] DOW_LAST = DOW_W'(7);

    logic [YEAR_W-1:0] year_q;
    logic [MON_W-1:0]  mon_q;
    logic [DAY_W-1:0]  day_q;
    logic [WOM_W-1:0]  wom_q;
    logic [DOW_W-1:0]  dow_q;
    logic [DOW_W-1:0]  nxt_dow;
    logic day_wrap, mon_wrap;

    // Next-state date for one day of advance, with month and year carries.
    always_comb begin
        day_wrap   = day_q >= last_day(year_q, mon_q);
        mon_wrap   = mon_q >= MON_LAST;
        nxt_day_o  = day_q;
        nxt_mon_o  = mon_q;
        nxt_year_o = year_q;
        nxt_dow    = dow_q;
        if (adv_i) begin
            nxt_dow   = (dow_q >= DOW_LAST) ? DOW_W'(1) : dow_q + 1'b1;
            nxt_day_o = day_wrap ? DAY_W'(1) : day_q + 1'b1;
            if (day_wrap) begin
                nxt_mon_o = mon_wrap ? MON_W'(1) : mon_q + 1'b1;
                if (mon_wrap) begin
                    nxt_year_o = year_q + 1'b1;
                end
            end
        end
    end

    // Date registers: reset, date load, time load, or day advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            year_q <= RESET_YEAR;
            mon_q  <= MON_W'(1);
            day_q  <= DAY_W'(1);
            wom_q  <= WOM_W'(1);
            dow_q  <= DOW_W'(1);
        end else if (ld_date_i) begin
            year_q <= ld_year_i;
            mon_q  <= ld_mon_i;
            day_q  <= ld_day_i;
            wom_q  <= week_of(ld_day_i);
        end else if (ld_time_i) begin
            wom_q  <= ld_wom_i;
            dow_q  <= ld_dow_i;
        end else if (adv_i) begin
            year_q <= nxt_year_o;
            mon_q  <= nxt_mon_o;
            day_q  <= nxt_day_o;
            wom_q  <= week_of(nxt_day_o);
            dow_q  <= nxt_dow;
        end
    end

    assign year_o = year_q;
    assign mon_o  = mon_q;
    assign day_o  = day_q;
    assign wom_o  = wom_q;
    assign dow_o  = dow_q;

    // R5: the day after December 31 is January 1 of the next year
    assert_year_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !ld_date_i && !ld_time_i && mon_q == MON_LAST && day_q >= DAY_W'(31))
        |=> (mon_q == MON_W'(1) && day_q == DAY_W'(1) && year_q == YEAR_W'($past(year_q) + 1'b1)));

    // R6: weekday wraps from 7 to 1 on a day carry
    assert_dow_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !ld_date_i && !ld_time_i && dow_q == DOW_LAST) |=> (dow_q == DOW_W'(1)));

    // R3: without an advance or load the date holds
    assert_date_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_i && !ld_date_i && !ld_time_i) |=> ($stable(day_q) && $stable(mon_q) && $stable(year_q)));

endmodule

// File: rtl/cal_alarm.sv
// Alarm registers and match detector.
// Assumes the candidate inputs are the calendar's next-state values and that
// upd_i marks an accepted tick. Only the date and clock fields are compared.
module cal_alarm
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_date_i,
    input  logic              ld_time_i,
    input  logic [TIME_W-1:0] wr_data_i,
    input  logic              upd_i,
    input  logic [DATE_W-1:0] cand_date_i,
    input  logic [CLK_W-1:0]  cand_clk_i,
    output logic [DATE_W-1:0] alarm_date_o,
    output logic [TIME_W-1:0] alarm_time_o,
    output logic              match_o
);
    logic [DATE_W-1:0] alm_date_q;
    logic [TIME_W-1:0] alm_time_q;
    logic              match_q;
    logic              hit;

    // Compare the advanced calendar with the alarm, ignoring week and weekday.
    always_comb begin
        hit = upd_i && (cand_date_i == alm_date_q) && (cand_clk_i == alm_time_q[CLK_W-1:0]);
    end

    // Alarm storage and registered match pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alm_date_q <= '0;
            alm_time_q <= '0;
            match_q    <= 1'b0;
        end else begin
            if (ld_date_i) alm_date_q <= wr_data_i[DATE_W-1:0];
            if (ld_time_i) alm_time_q <= wr_data_i;
            match_q <= hit;
        end
    end

    assign alarm_date_o = alm_date_q;
    assign alarm_time_o = alm_time_q;
    assign match_o      = match_q;

    // R9: the match pulse lasts a single clock
    assert_match_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        match_q |=> !match_q);

    // R10: a match only follows an accepted tick, never a plain write
    assert_match_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_i |=> !match_q);

endmodule

// File: rtl/cal_keeper.sv
// Calendar counter with alarm match: top level.
// Decodes the write port, blocks ticks in cycles with a calendar write,
// and assembles the packed date and time words from the counters.
module cal_keeper
    import cal_pkg::*;
#(
    parameter int unsigned RESET_YEAR = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [TIME_W-1:0] wr_data_i,
    output logic [DATE_W-1:0] date_o,
    output logic [TIME_W-1:0] time_o,
    output logic [DATE_W-1:0] alarm_date_o,
    output logic [TIME_W-1:0] alarm_time_o,
    output logic              match_o
);
    logic wr_cal_date, wr_cal_time, wr_alm_date, wr_alm_time, tick_ok;
    logic [HR_W-1:0]   hour, nxt_hour;
    logic [MIN_W-1:0]  minute, nxt_min;
    logic [SEC_W-1:0]  sec, nxt_sec;
    logic [YEAR_W-1:0] year, nxt_year;
    logic [MON_W-1:0]  mon, nxt_mon;
    logic [DAY_W-1:0]  day, nxt_day;
    logic [WOM_W-1:0]  wom;
    logic [DOW_W-1:0]  dow;
    logic              day_carry;

    // Write decode; a calendar write takes priority and drops a tick.
    always_comb begin
        wr_cal_date = wr_en_i && (wr_sel_i == TGT_CAL_DATE);
        wr_cal_time = wr_en_i && (wr_sel_i == TGT_CAL_TIME);
        wr_alm_date = wr_en_i && (wr_sel_i == TGT_ALM_DATE);
        wr_alm_time = wr_en_i && (wr_sel_i == TGT_ALM_TIME);
        tick_ok     = tick_i && !wr_cal_date && !wr_cal_time;
    end

    cal_tod u_tod (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_ok),
        .load_i      (wr_cal_time),
        .ld_hour_i   (wr_data_i[SEC_W+MIN_W +: HR_W]),
        .ld_min_i    (wr_data_i[SEC_W +: MIN_W]),
        .ld_sec_i    (wr_data_i[SEC_W-1:0]),
        .hour_o      (hour),
        .min_o       (minute),
        .sec_o       (sec),
        .nxt_hour_o  (nxt_hour),
        .nxt_min_o   (nxt_min),
        .nxt_sec_o   (nxt_sec),
        .day_carry_o (day_carry)
    );

    cal_date #(
        .RESET_YEAR (YEAR_W'(RESET_YEAR))
    ) u_date (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (day_carry),
        .ld_date_i  (wr_cal_date),
        .ld_time_i  (wr_cal_time),
        .ld_year_i  (wr_data_i[DAY_W+MON_W +: YEAR_W]),
        .ld_mon_i   (wr_data_i[DAY_W +: MON_W]),
        .ld_day_i   (wr_data_i[DAY_W-1:0]),
        .ld_wom_i   (wr_data_i[CLK_W+DOW_W +: WOM_W]),
        .ld_dow_i   (wr_data_i[CLK_W +: DOW_W]),
        .year_o     (year),
        .mon_o      (mon),
        .day_o      (day),
        .wom_o      (wom),
        .dow_o      (dow),
        .nxt_year_o (nxt_year),
        .nxt_mon_o  (nxt_mon),
        .nxt_day_o  (nxt_day)
    );

    cal_alarm u_alarm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ld_date_i    (wr_alm_date),
        .ld_time_i    (wr_alm_time),
        .wr_data_i    (wr_data_i),
        .upd_i        (tick_ok),
        .cand_date_i  ({nxt_year, nxt_mon, nxt_day}),
        .cand_clk_i   ({nxt_hour, nxt_min, nxt_sec}),
        .alarm_date_o (alarm_date_o),
        .alarm_time_o (alarm_time_o),
        .match_o      (match_o)
    );

    assign date_o = {year, mon, day};
    assign time_o = {wom, dow, hour, minute, sec};

endmodule

// File: tb/test_cal_keeper.sv
module test_cal_keeper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [22:0] wr_data = '0;
    logic [20:0] date_w, alm_date_w;
    logic [22:0] time_w, alm_time_w;
    logic        match;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    cal_keeper i_cal_keeper (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick),
        .wr_en_i      (wr_en),
        .wr_sel_i     (wr_sel),
        .wr_data_i    (wr_data),
        .date_o       (date_w),
        .time_o       (time_w),
        .alarm_date_o (alm_date_w),
        .alarm_time_o (alm_time_w),
        .match_o      (match)
    );

    function automatic logic [20:0] mk_date(int y, int m, int d);
        return {y[11:0], m[3:0], d[4:0]};
    endfunction

    function automatic logic [22:0] mk_time(int w, int wd, int h, int mi, int s);
        return {w[2:0], wd[2:0], h[4:0], mi[5:0], s[5:0]};
    endfunction

    task automatic check(input string req, input logic [22:0] act, input logic [22:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One-cycle write, results readable at the following falling edge.
    task automatic write_reg(input logic [1:0] sel, input logic [22:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    // Load a calendar, tick once, compare the result.
    task automatic adv_case(input string req, input logic [20:0] d0, input logic [22:0] t0,
                            input logic [20:0] d1, input logic [22:0] t1);
        write_reg(2'd0, d0);
        write_reg(2'd1, t0);
        pulse_tick();
        check({req, " date"}, 23'(date_w), 23'(d1));
        check({req, " time"}, time_w, t1);
    endtask

    task automatic test_reset();
        check("R1 date", 23'(date_w), 23'(mk_date(2000, 1, 1)));
        check("R1 time", time_w, mk_time(1, 1, 0, 0, 0));
        check("R1 alarm date", 23'(alm_date_w), '0);
        check("R1 alarm time", alm_time_w, '0);
        check("R1 match", 23'(match), '0);
    endtask

    task automatic test_time_of_day();
        adv_case("R2 second", mk_date(2024, 3, 14), mk_time(2, 4, 10, 20, 30),
                 mk_date(2024, 3, 14), mk_time(2, 4, 10, 20, 31));
        repeat (5) @(negedge clk);
        check("R2 hold", time_w, mk_time(2, 4, 10, 20, 31));
        adv_case("R2 hour carry", mk_date(2024, 3, 14), mk_time(2, 4, 10, 59, 59),
                 mk_date(2024, 3, 14), mk_time(2, 4, 11, 0, 0));
        adv_case("R2 R6 day carry", mk_date(2024, 3, 14), mk_time(2, 4, 23, 59, 59),
                 mk_date(2024, 3, 15), mk_time(3, 5, 0, 0, 0));
    endtask

    task automatic test_month_ends();
        adv_case("R3 R6 april end", mk_date(2023, 4, 30), mk_time(5, 7, 23, 59, 59),
                 mk_date(2023, 5, 1), mk_time(1, 1, 0, 0, 0));
        adv_case("R3 january end", mk_date(2023, 1, 31), mk_time(5, 2, 23, 59, 59),
                 mk_date(2023, 2, 1), mk_time(1, 3, 0, 0, 0));
        adv_case("R3 april 29", mk_date(2023, 4, 29), mk_time(5, 6, 23, 59, 59),
                 mk_date(2023, 4, 30), mk_time(5, 7, 0, 0, 0));
    endtask

    task automatic test_february();
        adv_case("R4 2024 feb 28", mk_date(2024, 2, 28), mk_time(4, 3, 23, 59, 59),
                 mk_date(2024, 2, 29), mk_time(5, 4, 0, 0, 0));
        adv_case("R4 2024 feb 29", mk_date(2024, 2, 29), mk_time(5, 4, 23, 59, 59),
                 mk_date(2024, 3, 1), mk_time(1, 5, 0, 0, 0));
        adv_case("R4 2023 feb 28", mk_date(2023, 2, 28), mk_time(4, 2, 23, 59, 59),
                 mk_date(2023, 3, 1), mk_time(1, 3, 0, 0, 0));
        adv_case("R4 1900 feb 28", mk_date(1900, 2, 28), mk_time(4, 1, 23, 59, 59),
                 mk_date(1900, 3, 1), mk_time(1, 2, 0, 0, 0));
        adv_case("R4 2000 feb 28", mk_date(2000, 2, 28), mk_time(4, 1, 23, 59, 59),
                 mk_date(2000, 2, 29), mk_time(5, 2, 0, 0, 0));
    endtask

    task automatic test_year_end();
        adv_case("R5 year end", mk_date(2023, 12, 31), mk_time(5, 7, 23, 59, 59),
                 mk_date(2024, 1, 1), mk_time(1, 1, 0, 0, 0));
    endtask

    task automatic test_week_on_write();
        write_reg(2'd1, mk_time(1, 3, 9, 8, 7));
        write_reg(2'd0, mk_date(2022, 7, 22));
        check("R6 week after date write", time_w, mk_time(4, 3, 9, 8, 7));
        check("R7 date readback", 23'(date_w), 23'(mk_date(2022, 7, 22)));
    endtask

    task automatic test_priority();
        write_reg(2'd0, mk_date(2024, 5, 5));
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = mk_time(1, 1, 12, 30, 45); tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        check("R8 write beats tick", time_w, mk_time(1, 1, 12, 30, 45));
        check("R8 no match", 23'(match), '0);
    endtask

    task automatic test_alarm();
        write_reg(2'd2, mk_date(2024, 6, 1));
        write_reg(2'd3, mk_time(7, 7, 8, 0, 0));
        check("R7 alarm date readback", 23'(alm_date_w), 23'(mk_date(2024, 6, 1)));
        check("R7 alarm time readback", alm_time_w, mk_time(7, 7, 8, 0, 0));
        // Writing the exact alarm value must not fire.
        write_reg(2'd0, mk_date(2024, 6, 1));
        check("R10 after date write", 23'(match), '0);
        write_reg(2'd1, mk_time(1, 6, 8, 0, 0));
        check("R10 after time write", 23'(match), '0);
        // Tick onto the alarm; week and weekday differ from the alarm.
        write_reg(2'd1, mk_time(1, 6, 7, 59, 59));
        pulse_tick();
        check("R9 match on tick", 23'(match), 23'd1);
        check("R9 time at match", time_w, mk_time(1, 6, 8, 0, 0));
        @(negedge clk);
        check("R9 pulse ends", 23'(match), '0);
        // Near misses: wrong second, then wrong year.
        adv_case("R9 second short", mk_date(2024, 6, 1), mk_time(1, 6, 7, 59, 58),
                 mk_date(2024, 6, 1), mk_time(1, 6, 7, 59, 59));
        check("R9 no match second", 23'(match), '0);
        adv_case("R9 other year", mk_date(2025, 6, 1), mk_time(1, 7, 7, 59, 59),
                 mk_date(2025, 6, 1), mk_time(1, 7, 8, 0, 0));
        check("R9 no match year", 23'(match), '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_time_of_day();
        test_month_ends();
        test_february();
        test_year_end();
        test_week_on_write();
        test_priority();
        test_alarm();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule